// File: doc/BRIEF.md
# Prioritized Secure/Non-Secure Interrupt Router

This block gathers 128 level-sensitive interrupt lines and reduces them to two requests for a processor: a normal request (`irq_o`) and a fast request (`fiq_o`). Each source carries an enable bit, a routing bit that selects between the secure (fast) path and the non-secure (normal) path, and an 8-bit priority. Sources are organised in four groups of 32 for the per-bit registers. Priorities are packed four to a 32-bit word.

For the non-secure path, a comparison tree picks the most urgent pending source. It uses only the upper nibble of each priority, and a tie goes to the lower source number. The normal request is raised only when that winner beats a programmable priority threshold and both the global enable and the non-secure enable are on. Any pending secure source raises the fast request whenever the global enable is on. Software uses a plain word-addressed register port: address, write strobe, write data, and combinational read data. Both request outputs are registered.

Top module: `prio_irq_router`

## Requirements
- R1: After reset, every enable, routing bit, priority field, the threshold and both control bits read as 0, and `irq_o` and `fiq_o` are low.
- R2: Enables change only through two register sets. Writing 1s to word 0x10+g enables those bits of group g, and writing 1s to word 0x14+g disables them. Zero bits leave state unchanged. Reading either address returns the group's enable mask.
- R3: Word 0x18+g (read-only) shows the sources of group g that are both asserted and enabled. A disabled source never appears there.
- R4: The priority of source n is stored in word 0x20+n/4 at bits [(n%4)*8+7:(n%4)*8] and reads back as written. Only bits [7:4] take part in any comparison, and a lower value is more urgent.
- R5: Word 0x1C+g holds the routing bits of group g. A 1 routes the source to the non-secure (`irq_o`) path and a 0 routes it to the secure (`fiq_o`) path.
- R6: `fiq_o` is high exactly one clock after a cycle in which the global enable is set and at least one enabled, asserted source has routing bit 0. The threshold has no effect on it.
- R7: `irq_o` is high exactly one clock after a cycle in which the global enable and the non-secure enable are set and the winner's priority bits [7:4] are numerically below threshold bits [7:4].
- R8: Word 0x0 is control. Bit 0 is the global enable. Bit 1 is the non-secure enable, and a write updates it only when bit 2 of the same write is 1. Reads return bits [1:0]. While the global enable is 0, both outputs are low one clock later.
- R9: Word 0x2 (read-only) reports the winner. Bit 31 is a valid flag and bits [6:0] hold the source number of the most urgent pending non-secure source, with ties going to the lowest number. The word reads 0 when no such source is pending.
- R10: Pending state follows the input level without latching. When a line drops, it leaves the pending and winner reads at once, and the outputs follow one clock later.
- R11: Word 0x1 holds the 8-bit priority threshold, readable and writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_src | input | 128 | Level-sensitive interrupt lines, bit n is source n |
| reg_addr | input | 8 | Word address of the register port |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq_o | output | 1 | Registered non-secure interrupt request |
| fiq_o | output | 1 | Registered secure interrupt request |

## Verification
On every cycle, the assertions check how the two outputs follow their qualifying conditions one clock later. This covers the global-enable gate, the non-secure gate and the threshold comparison. They also check that any reported winner is a pending non-secure source, and that writes to set or clear an enable take effect on the next cycle. Other behaviour can only be shown by the directed scenarios, because the expected values come from the stimulus. This includes the register layout and the packing of priority fields, the fact that zero bits leave enables untouched, the tie-break toward the lowest source, the use of only the upper priority nibble, the masked write of the non-secure enable bit, and the rerouting of a source to the fast path.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
    localparam int unsigned SRC_N  = 128;
    localparam int unsigned GRP_W  = 32;
    localparam int unsigned PRIO_W = 8;
    localparam int unsigned KEY_W  = 4;
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned DATA_W = 32;

    localparam int unsigned A_CTRL  = 0;
    localparam int unsigned A_PMASK = 1;
    localparam int unsigned A_WIN   = 2;

    // Register blocks are laid out back to back from word 16.
    function automatic int unsigned base_enset(int unsigned ngrp);
        base_enset = 16 + 0 * ngrp;
    endfunction
    function automatic int unsigned base_enclr(int unsigned ngrp);
        base_enclr = 16 + 1 * ngrp;
    endfunction
    function automatic int unsigned base_pend(int unsigned ngrp);
        base_pend = 16 + 2 * ngrp;
    endfunction
    function automatic int unsigned base_sec(int unsigned ngrp);
        base_sec = 16 + 3 * ngrp;
    endfunction
    function automatic int unsigned base_prio(int unsigned ngrp);
        base_prio = 16 + 4 * ngrp;
    endfunction
endpackage

// File: rtl/irq_cfg_bank.sv
module irq_cfg_bank
    import prio_irq_pkg::*;
#(
    parameter int unsigned NUM_SRC = SRC_N,
    parameter int unsigned GW      = GRP_W,
    parameter int unsigned PW      = PRIO_W,
    parameter int unsigned AW      = ADDR_W,
    parameter int unsigned DW      = DATA_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [AW-1:0]               addr,
    input  logic [DW-1:0]               wdata,
    output logic [NUM_SRC-1:0]          en_o,
    output logic [NUM_SRC-1:0]          sec_o,
    output logic [NUM_SRC-1:0][PW-1:0]  prio_o
);
    localparam int unsigned NGRP     = NUM_SRC / GW;
    localparam int unsigned PER_WORD = DW / PW;
    localparam int unsigned NWORD    = NUM_SRC / PER_WORD;
    localparam int unsigned B_SET    = base_enset(NGRP);
    localparam int unsigned B_CLR    = base_enclr(NGRP);
    localparam int unsigned B_SEC    = base_sec(NGRP);
    localparam int unsigned B_PRIO   = base_prio(NGRP);

    typedef struct packed {
        logic [NUM_SRC-1:0]         en;
        logic [NUM_SRC-1:0]         sec;
        logic [NUM_SRC-1:0][PW-1:0] prio;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (we) begin
            for (int g = 0; g < NGRP; g++) begin
                if (addr == AW'(B_SET + g))
                    bank_d.en[g*GW +: GW] = bank_q.en[g*GW +: GW] | wdata[GW-1:0];
                if (addr == AW'(B_CLR + g))
                    bank_d.en[g*GW +: GW] = bank_q.en[g*GW +: GW] & ~wdata[GW-1:0];
                if (addr == AW'(B_SEC + g))
                    bank_d.sec[g*GW +: GW] = wdata[GW-1:0];
            end
            for (int w = 0; w < NWORD; w++) begin
                if (addr == AW'(B_PRIO + w)) begin
                    for (int j = 0; j < PER_WORD; j++)
                        bank_d.prio[w*PER_WORD + j] = wdata[j*PW +: PW];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign en_o   = bank_q.en;
    assign sec_o  = bank_q.sec;
    assign prio_o = bank_q.prio;
endmodule

// File: rtl/irq_win_tree.sv
module irq_win_tree
    import prio_irq_pkg::*;
#(
    parameter int unsigned NUM_SRC = SRC_N,
    parameter int unsigned PW      = PRIO_W,
    parameter int unsigned KW      = KEY_W
) (
    input  logic [NUM_SRC-1:0]          req,
    input  logic [NUM_SRC-1:0][PW-1:0]  prio,
    output logic                        win_valid,
    output logic [$clog2(NUM_SRC)-1:0]  win_id,
    output logic [KW-1:0]               win_key
);
    // NUM_SRC must be a power of two: a full heap of comparators.
    localparam int unsigned ID_W  = $clog2(NUM_SRC);
    localparam int unsigned NODES = 2 * NUM_SRC - 1;

    typedef struct packed {
        logic            valid;
        logic [KW-1:0]   key;
        logic [ID_W-1:0] id;
    } cand_t;

    // Left operand always covers lower source numbers, so ties keep it.
    function automatic cand_t pick(cand_t lo, cand_t hi);
        if (lo.valid && (!hi.valid || lo.key <= hi.key)) pick = lo;
        else                                               pick = hi;
    endfunction

    cand_t heap [NODES];

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_leaf
        assign heap[NUM_SRC - 1 + k].valid = req[k];
        assign heap[NUM_SRC - 1 + k].key   = prio[k][PW-1 -: KW];
        assign heap[NUM_SRC - 1 + k].id    = ID_W'(k);
    end

    for (genvar i = 0; i < NUM_SRC - 1; i++) begin : g_node
        assign heap[i] = pick(heap[2*i + 1], heap[2*i + 2]);
    end

    assign win_valid = heap[0].valid;
    assign win_id    = heap[0].valid ? heap[0].id  : '0;
    assign win_key   = heap[0].valid ? heap[0].key : '0;
endmodule

// File: rtl/prio_irq_router.sv
module prio_irq_router
    import prio_irq_pkg::*;
#(
    parameter int unsigned NUM_SRC = SRC_N,
    parameter int unsigned GW      = GRP_W,
    parameter int unsigned PW      = PRIO_W,
    parameter int unsigned KW      = KEY_W,
    parameter int unsigned AW      = ADDR_W,
    parameter int unsigned DW      = DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_src,
    input  logic [AW-1:0]      reg_addr,
    input  logic               reg_we,
    input  logic [DW-1:0]      reg_wdata,
    output logic [DW-1:0]      reg_rdata,
    output logic               irq_o,
    output logic               fiq_o
);
    localparam int unsigned NGRP     = NUM_SRC / GW;
    localparam int unsigned PER_WORD = DW / PW;
    localparam int unsigned NWORD    = NUM_SRC / PER_WORD;
    localparam int unsigned ID_W     = $clog2(NUM_SRC);
    localparam int unsigned B_SET    = base_enset(NGRP);
    localparam int unsigned B_CLR    = base_enclr(NGRP);
    localparam int unsigned B_PEND   = base_pend(NGRP);
    localparam int unsigned B_SEC    = base_sec(NGRP);
    localparam int unsigned B_PRIO   = base_prio(NGRP);

    typedef struct packed {
        logic          gen;
        logic          nsen;
        logic [PW-1:0] pmask;
        logic          irq;
        logic          fiq;
    } top_t;

    top_t st_d, st_q;

    logic [NUM_SRC-1:0]         en_v, sec_v, pend_v;
    logic [NUM_SRC-1:0][PW-1:0] prio_v;
    logic                       win_valid;
    logic [ID_W-1:0]            win_id;
    logic [KW-1:0]              win_key;
    logic [KW-1:0]              mask_key;

    irq_cfg_bank #(
        .NUM_SRC(NUM_SRC), .GW(GW), .PW(PW), .AW(AW), .DW(DW)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .en_o   (en_v),
        .sec_o  (sec_v),
        .prio_o (prio_v)
    );

    assign pend_v   = irq_src & en_v;
    assign mask_key = st_q.pmask[PW-1 -: KW];

    irq_win_tree #(
        .NUM_SRC(NUM_SRC), .PW(PW), .KW(KW)
    ) u_tree (
        .req       (pend_v & sec_v),
        .prio      (prio_v),
        .win_valid (win_valid),
        .win_id    (win_id),
        .win_key   (win_key)
    );

    always_comb begin
        st_d = st_q;
        if (reg_we && reg_addr == AW'(A_CTRL)) begin
            st_d.gen = reg_wdata[0];
            if (reg_wdata[2]) st_d.nsen = reg_wdata[1];
        end
        if (reg_we && reg_addr == AW'(A_PMASK))
            st_d.pmask = reg_wdata[PW-1:0];
        st_d.irq = st_q.gen && st_q.nsen && win_valid && (win_key < mask_key);
        st_d.fiq = st_q.gen && |(pend_v & ~sec_v);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == AW'(A_CTRL)) begin
            reg_rdata[0] = st_q.gen;
            reg_rdata[1] = st_q.nsen;
        end
        if (reg_addr == AW'(A_PMASK))
            reg_rdata[PW-1:0] = st_q.pmask;
        if (reg_addr == AW'(A_WIN)) begin
            reg_rdata[DW-1]     = win_valid;
            reg_rdata[ID_W-1:0] = win_id;
        end
        for (int g = 0; g < NGRP; g++) begin
            if (reg_addr == AW'(B_SET + g) || reg_addr == AW'(B_CLR + g))
                reg_rdata[GW-1:0] = en_v[g*GW +: GW];
            if (reg_addr == AW'(B_PEND + g))
                reg_rdata[GW-1:0] = pend_v[g*GW +: GW];
            if (reg_addr == AW'(B_SEC + g))
                reg_rdata[GW-1:0] = sec_v[g*GW +: GW];
        end
        for (int w = 0; w < NWORD; w++) begin
            if (reg_addr == AW'(B_PRIO + w)) begin
                for (int j = 0; j < PER_WORD; j++)
                    reg_rdata[j*PW +: PW] = prio_v[w*PER_WORD + j];
            end
        end
    end

    assign irq_o = st_q.irq;
    assign fiq_o = st_q.fiq;
endmodule

// File: rtl/prio_irq_router_chk.sv
module prio_irq_router_chk
    import prio_irq_pkg::*;
#(
    parameter int unsigned NUM_SRC = SRC_N,
    parameter int unsigned KW      = KEY_W,
    parameter int unsigned AW      = ADDR_W,
    parameter int unsigned DW      = DATA_W,
    parameter int unsigned NGRP    = SRC_N / GRP_W
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       irq_o,
    input logic                       fiq_o,
    input logic                       reg_we,
    input logic [AW-1:0]              reg_addr,
    input logic [DW-1:0]              reg_wdata,
    input logic                       gen,
    input logic                       nsen,
    input logic [KW-1:0]              mask_key,
    input logic [NUM_SRC-1:0]         en,
    input logic [NUM_SRC-1:0]         pend,
    input logic [NUM_SRC-1:0]         sec,
    input logic                       win_valid,
    input logic [$clog2(NUM_SRC)-1:0] win_id,
    input logic [KW-1:0]              win_key
);
    localparam int unsigned B_SET = base_enset(NGRP);
    localparam int unsigned B_CLR = base_enclr(NGRP);

    assert_gen_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !gen |=> (!irq_o && !fiq_o));

    assert_fiq_raise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (gen && |(pend & ~sec)) |=> fiq_o);

    assert_fiq_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(pend & ~sec)) |=> !fiq_o);

    assert_irq_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gen && nsen && win_valid && (win_key < mask_key)) |=> irq_o);

    assert_irq_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!nsen || !win_valid || (win_key >= mask_key)) |=> !irq_o);

    assert_win_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (pend[win_id] && sec[win_id]));

    assert_enset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == AW'(B_SET) && reg_wdata[0]) |=> en[0]);

    assert_enclr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == AW'(B_CLR) && reg_wdata[0]) |=> !en[0]);
endmodule

bind prio_irq_router prio_irq_router_chk #(
    .NUM_SRC(NUM_SRC), .KW(KW), .AW(AW), .DW(DW), .NGRP(NGRP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .gen       (st_q.gen),
    .nsen      (st_q.nsen),
    .mask_key  (mask_key),
    .en        (en_v),
    .pend      (pend_v),
    .sec       (sec_v),
    .win_valid (win_valid),
    .win_id    (win_id),
    .win_key   (win_key)
);

// File: tb/test_prio_irq_router.sv
module test_prio_irq_router;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] irq_src = '0;
    logic [7:0]   reg_addr = '0;
    logic         reg_we = 1'b0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         irq_o, fiq_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    prio_irq_router i_prio_irq_router (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_src   (irq_src),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_o     (irq_o),
        .fiq_o     (fiq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic settle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 irq_o", {31'b0, irq_o}, 0);
        check("R1 fiq_o", {31'b0, fiq_o}, 0);
        rd(8'h00, v); check("R1 ctrl", v, 0);
        rd(8'h01, v); check("R1 threshold", v, 0);
        rd(8'h02, v); check("R1 winner", v, 0);
        for (int g = 0; g < 4; g++) begin
            rd(8'h10 + 8'(g), v); check("R1 enable", v, 0);
            rd(8'h1C + 8'(g), v); check("R1 routing", v, 0);
        end
        rd(8'h20, v); check("R1 priority word", v, 0);
    endtask

    task automatic t_enables();
        logic [31:0] v;
        wr(8'h10, 32'h0000_00F0);
        wr(8'h10, 32'h0000_0001);
        rd(8'h10, v); check("R2 set keeps zeros", v, 32'h0000_00F1);
        wr(8'h14, 32'h0000_0010);
        rd(8'h10, v); check("R2 clear one bit", v, 32'h0000_00E1);
        rd(8'h14, v); check("R2 read via clear addr", v, 32'h0000_00E1);
        rd(8'h11, v); check("R2 other group untouched", v, 0);
    endtask

    task automatic t_pending();
        logic [31:0] v;
        @(negedge clk); irq_src[7:0] = 8'hFF;
        rd(8'h18, v); check("R3 pending masked by enable", v, 32'h0000_00E1);
        @(negedge clk); irq_src[5] = 1'b0;
        rd(8'h18, v); check("R10 pending follows level", v, 32'h0000_00C1);
    endtask

    task automatic t_fast();
        logic [31:0] v;
        settle();
        check("R8 fiq held low without global enable", {31'b0, fiq_o}, 0);
        wr(8'h00, 32'h1);
        settle();
        check("R6 fiq from secure source", {31'b0, fiq_o}, 1);
        check("R6 irq stays low", {31'b0, irq_o}, 0);
        wr(8'h00, 32'h0);
        settle();
        check("R8 fiq drops after global disable", {31'b0, fiq_o}, 0);
    endtask

    task automatic t_normal();
        logic [31:0] v;
        @(negedge clk); irq_src = '0;
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h1D, 32'hFFFF_FFFF);
        wr(8'h11, 32'h0000_0160);
        wr(8'h29, 32'h0030_3F00);
        wr(8'h2A, 32'h0000_0050);
        rd(8'h29, v); check("R4 packed priority word", v, 32'h0030_3F00);
        rd(8'h1D, v); check("R5 routing readback", v, 32'hFFFF_FFFF);
        @(negedge clk); irq_src[37] = 1'b1; irq_src[38] = 1'b1; irq_src[40] = 1'b1;
        rd(8'h02, v); check("R9 R4 tie on upper nibble to lower id", v, 32'h8000_0025);
        wr(8'h00, 32'h3);
        rd(8'h00, v); check("R8 ns enable ignored without write mask", v, 32'h1);
        wr(8'h00, 32'h7);
        rd(8'h00, v); check("R8 ns enable with write mask", v, 32'h3);
        wr(8'h01, 32'h30);
        rd(8'h01, v); check("R11 threshold readback", v, 32'h30);
        settle();
        check("R7 equal to threshold blocks irq", {31'b0, irq_o}, 0);
        wr(8'h01, 32'h4F);
        settle();
        check("R7 below threshold raises irq", {31'b0, irq_o}, 1);
        check("R6 fiq low with no secure source", {31'b0, fiq_o}, 0);
    endtask

    task automatic t_level();
        logic [31:0] v;
        @(negedge clk); irq_src[37] = 1'b0;
        rd(8'h02, v); check("R10 winner moves on drop", v, 32'h8000_0026);
        settle();
        check("R7 irq kept by next winner", {31'b0, irq_o}, 1);
        @(negedge clk); irq_src[38] = 1'b0; irq_src[40] = 1'b0;
        #1 check("R10 irq still high before edge", {31'b0, irq_o}, 1);
        rd(8'h02, v); check("R9 winner invalid when idle", v, 0);
        settle();
        check("R10 irq drops one clock later", {31'b0, irq_o}, 0);
    endtask

    task automatic t_reroute();
        logic [31:0] v;
        wr(8'h1D, 32'hFFFF_FEFF);
        @(negedge clk); irq_src[40] = 1'b1;
        rd(8'h02, v); check("R5 secure source not a winner", v, 0);
        settle();
        check("R5 rerouted source drives fiq", {31'b0, fiq_o}, 1);
        check("R5 rerouted source leaves irq", {31'b0, irq_o}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enables();
        t_pending();
        t_fast();
        t_normal();
        t_level();
        t_reroute();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule